// File: doc/BRIEF.md
# Bisync Character-Sync Receiver

This block is the receive half of a byte-oriented synchronous serial link. It takes one serial bit per `bit_tick` pulse, least significant bit of each character first, and searches the incoming stream one bit at a time for a programmed SYN1 pattern. Once it has found SYN1, and also SYN2 when double-SYN framing is selected, it holds character alignment. It then assembles characters of 5 to 8 data bits with an optional parity bit and places them in a holding register that the host drains with a read strobe.

Framing, transparency and stripping are set by static configuration inputs. In normal framing the block can drop SYN fill characters. In transparent framing it drops the DLE escape and DLE-SYN1 fill pairs, and it flags a DLE followed by an ordinary character. An external jam-sync pulse can replace pattern hunting, so that the next received bit becomes the first bit of a character. Receive enable works as a soft restart: while it is low, alignment and the holding state are cleared, and a rising edge starts a fresh hunt.

Top module: `bisync_rx`

## Requirements
- R1: After reset, rx_ready, syn_det, dle_det, par_err, overrun and in_sync are 0 and rx_data is 0.
- R2: With rx_en high, single_syn=1 and jam_sel=0, the receiver compares the last character-width bits against SYN1 after every bit. A match sets in_sync and syn_det in that bit's cycle. The matching characters are never loaded.
- R3: With single_syn=0, the character that directly follows the SYN1 match must equal SYN2 for in_sync and syn_det to be set. Any other character returns the receiver to hunting, so the stream SYN1, SYN1, SYN2 gives no sync.
- R4: len_sel selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits, received LSB first. Bits above the character length read as 0 in rx_data.
- R5: With par_en=1, one parity bit follows the data bits (par_odd=1 odd, 0 even). A loaded character with a wrong parity bit sets par_err, and err_clear clears it.
- R6: Loading a character while rx_ready is still 1 sets overrun, which stays set until err_clear.
- R7: rx_ready is set only when a character is loaded and cleared by data_read. A status_read pulse clears syn_det.
- R8: With strip_en=1 and transparent=0, a SYN1 character is not loaded. In double-SYN mode a SYN2 that directly follows SYN1 is also not loaded, while a SYN2 that does not follow SYN1 is loaded.
- R9: With strip_en=1 and transparent=1, a DLE is not loaded and a SYN1 directly after a DLE is not loaded. The second DLE of a DLE-DLE pair is loaded, and a SYN1 without a preceding DLE is loaded.
- R10: While in sync, syn_det is set by DLE-SYN1 in transparent mode, by SYN1 in single-SYN mode, and by SYN1-SYN2 in double-SYN mode, whether or not the characters are stripped.
- R11: With transparent=1 and par_en=0, a DLE followed by a character other than DLE or SYN1 sets dle_det. The next character after a DLE updates the flag, and err_clear or rx_en low clears it.
- R12: With jam_sel=1, pattern hunting is off. After a rising edge on jam_in, the next ticked bit is bit 0 of a character, and in_sync and syn_det are set.
- R13: rx_en low clears rx_ready, dle_det, syn_det and in_sync. The next rising edge restarts the hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; a rising edge starts a hunt |
| rx_bit | input | 1 | Serial data bit |
| bit_tick | input | 1 | One-cycle strobe marking a valid rx_bit |
| syn1 | input | 8 | First sync pattern |
| syn2 | input | 8 | Second sync pattern |
| dle | input | 8 | Escape character |
| len_sel | input | 2 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 odd, 0 even parity |
| single_syn | input | 1 | 1 single-SYN, 0 double-SYN |
| transparent | input | 1 | Transparent framing |
| strip_en | input | 1 | Drop control characters |
| jam_sel | input | 1 | External jam sync replaces hunting |
| jam_in | input | 1 | Jam sync pulse |
| err_clear | input | 1 | Clears par_err, overrun, dle_det |
| data_read | input | 1 | Host took rx_data |
| status_read | input | 1 | Host read flags; clears syn_det |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Holding register full |
| par_err | output | 1 | Parity error seen |
| overrun | output | 1 | Unread character overwritten |
| syn_det | output | 1 | Sync sequence seen |
| dle_det | output | 1 | DLE followed by ordinary character |
| in_sync | output | 1 | Character alignment held |

## Verification
A wrong bit count or a wrong hunt comparator moves every later boundary, so the very next character shows at rx_data with its bits rotated, or in_sync never rises. A broken stripping history (previous-SYN1 or open-DLE state) shows at the end of the next character as an unexpected rx_ready or a missing syn_det. Flag handling errors appear one cycle after the load or strobe that should have changed them.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  parameter int unsigned BSR_W = 8;
  typedef logic [BSR_W-1:0] bsr_char_t;
  typedef enum logic [1:0] {ST_OFF, ST_HUNT, ST_CONF, ST_SYNC} bsr_state_e;

  // data bits per character: code 0..3 -> BSR_W-3 .. BSR_W
  function automatic int unsigned len_bits(input logic [1:0] code);
    return BSR_W - 3 + int'(code);
  endfunction

  function automatic bsr_char_t len_mask(input logic [1:0] code);
    bsr_char_t m;
    m = '1;
    return ~(m << len_bits(code));
  endfunction

  // newest bit sits at the MSB; the character is the top len bits
  function automatic bsr_char_t pick_char(input bsr_char_t sh, input logic [1:0] code);
    return sh >> (BSR_W - len_bits(code));
  endfunction

  function automatic logic parity_wrong(input bsr_char_t d, input logic pbit, input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction
endpackage

// File: rtl/bsr_deser.sv
module bsr_deser
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bit_in,
  input  logic       hunting,
  input  logic       assembling,
  input  logic       jam_go,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  bsr_char_t  syn1,
  output logic       hunt_hit,
  output logic       char_done,
  output bsr_char_t  char_val,
  output logic       par_bad
);
  localparam int CNT_W = $clog2(BSR_W + 2);

  logic [CNT_W-1:0] cnt, nlen, last;
  bsr_char_t sh, sh_nx;
  logic skip, shift_en, at_last;

  assign nlen     = CNT_W'(len_bits(len_sel));
  assign last     = nlen + CNT_W'(par_en) - CNT_W'(1);
  assign shift_en = tick && (hunting || jam_go || (assembling && cnt < nlen));
  assign sh_nx    = shift_en ? {bit_in, sh[BSR_W-1:1]} : sh;
  assign char_val = pick_char(sh_nx, len_sel);
  assign hunt_hit = tick && hunting && (char_val == (syn1 & len_mask(len_sel)));
  assign at_last  = tick && assembling && !jam_go && (cnt == last);
  assign char_done = at_last && !skip;
  assign par_bad  = par_en && parity_wrong(char_val, bit_in, par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      skip <= 1'b0;
    end else begin
      sh <= sh_nx;
      if (tick && jam_go) begin
        cnt  <= CNT_W'(1);
        skip <= 1'b0;
      end else if (!(hunting || assembling)) begin
        cnt  <= '0;
        skip <= 1'b0;
      end else if (hunt_hit) begin
        // parity bit of the matched SYN1 is consumed as a silent character end
        cnt  <= par_en ? nlen : '0;
        skip <= par_en;
      end else if (tick && assembling) begin
        if (cnt == last) begin
          cnt  <= '0;
          skip <= 1'b0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bsr_filter.sv
module bsr_filter
  import bsr_pkg::*;
(
  input  bsr_char_t val,
  input  bsr_char_t syn1_m,
  input  bsr_char_t syn2_m,
  input  bsr_char_t dle_m,
  input  logic      single_syn,
  input  logic      transparent,
  input  logic      strip_en,
  input  logic      jam_sel,
  input  logic      par_en,
  input  logic      prev_s1,
  input  logic      dle_open,
  output logic      drop,
  output logic      syn_hit,
  output logic      dle_val,
  output logic      nxt_prev_s1,
  output logic      nxt_dle_open
);
  logic is_s1, is_s2, is_dle;

  assign is_s1  = (val == syn1_m);
  assign is_s2  = (val == syn2_m);
  assign is_dle = (val == dle_m);

  always_comb begin
    if (transparent) begin
      drop    = strip_en && ((is_dle && !dle_open) || (is_s1 && dle_open));
      syn_hit = !jam_sel && dle_open && is_s1;
    end else if (single_syn) begin
      drop    = strip_en && is_s1;
      syn_hit = !jam_sel && is_s1;
    end else begin
      drop    = strip_en && (is_s1 || (is_s2 && prev_s1));
      syn_hit = !jam_sel && prev_s1 && is_s2;
    end
  end

  assign dle_val      = !par_en && !is_dle && !is_s1;
  assign nxt_prev_s1  = is_s1;
  assign nxt_dle_open = transparent && is_dle && !dle_open;
endmodule

// File: rtl/bsr_hold.sv
module bsr_hold
  import bsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear_all,
  input  logic      ld,
  input  bsr_char_t val,
  input  logic      par_bad,
  input  logic      syn_set,
  input  logic      dle_upd,
  input  logic      dle_val,
  input  logic      data_read,
  input  logic      status_read,
  input  logic      err_clear,
  output bsr_char_t rx_data,
  output logic      rx_ready,
  output logic      par_err,
  output logic      overrun,
  output logic      syn_det,
  output logic      dle_det
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      overrun  <= 1'b0;
      syn_det  <= 1'b0;
      dle_det  <= 1'b0;
    end else begin
      if (ld) rx_data <= val;

      if (clear_all)      rx_ready <= 1'b0;
      else if (ld)        rx_ready <= 1'b1;
      else if (data_read) rx_ready <= 1'b0;

      if (ld && rx_ready && !data_read) overrun <= 1'b1;
      else if (err_clear)               overrun <= 1'b0;

      if (ld && par_bad)  par_err <= 1'b1;
      else if (err_clear) par_err <= 1'b0;

      if (clear_all)        syn_det <= 1'b0;
      else if (syn_set)     syn_det <= 1'b1;
      else if (status_read) syn_det <= 1'b0;

      if (clear_all || err_clear) dle_det <= 1'b0;
      else if (dle_upd)           dle_det <= dle_val;
    end
  end
endmodule

// File: rtl/bisync_rx.sv
module bisync_rx
  import bsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       rx_bit,
  input  logic       bit_tick,
  input  logic [7:0] syn1,
  input  logic [7:0] syn2,
  input  logic [7:0] dle,
  input  logic [1:0] len_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       single_syn,
  input  logic       transparent,
  input  logic       strip_en,
  input  logic       jam_sel,
  input  logic       jam_in,
  input  logic       err_clear,
  input  logic       data_read,
  input  logic       status_read,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       par_err,
  output logic       overrun,
  output logic       syn_det,
  output logic       dle_det,
  output logic       in_sync
);
  bsr_state_e st, st_nx;
  bsr_char_t  syn1_m, syn2_m, dle_m, char_val;
  logic jam_q, jam_pend, jam_go, hunting, assembling;
  logic hunt_hit, char_done, par_bad, sync_char, conf_ok;
  logic prev_s1, dle_open, drop, syn_hit, dle_val, nxt_prev_s1, nxt_dle_open;
  logic ld, syn_set, dle_upd;

  assign syn1_m = syn1 & len_mask(len_sel);
  assign syn2_m = syn2 & len_mask(len_sel);
  assign dle_m  = dle  & len_mask(len_sel);

  assign jam_go     = bit_tick && jam_pend && jam_sel && (st != ST_OFF);
  assign hunting    = (st == ST_HUNT) && !jam_sel;
  assign assembling = (st == ST_CONF) || (st == ST_SYNC);

  bsr_deser u_deser (
    .clk, .rst_n, .tick(bit_tick), .bit_in(rx_bit), .hunting, .assembling, .jam_go,
    .len_sel, .par_en, .par_odd, .syn1(syn1_m),
    .hunt_hit, .char_done, .char_val, .par_bad
  );

  bsr_filter u_filter (
    .val(char_val), .syn1_m, .syn2_m, .dle_m, .single_syn, .transparent, .strip_en,
    .jam_sel, .par_en, .prev_s1, .dle_open,
    .drop, .syn_hit, .dle_val, .nxt_prev_s1, .nxt_dle_open
  );

  assign conf_ok   = (st == ST_CONF) && char_done && !jam_go && (char_val == syn2_m);
  assign sync_char = (st == ST_SYNC) && char_done;
  assign ld        = sync_char && !drop;
  assign dle_upd   = sync_char && dle_open;
  assign syn_set   = jam_go || (hunt_hit && single_syn) || conf_ok || (sync_char && syn_hit);

  always_comb begin
    st_nx = st;
    if (!rx_en) st_nx = ST_OFF;
    else begin
      case (st)
        ST_OFF:  st_nx = ST_HUNT;
        ST_HUNT: if (jam_go) st_nx = ST_SYNC;
                 else if (hunt_hit) st_nx = single_syn ? ST_SYNC : ST_CONF;
        ST_CONF: if (jam_go || conf_ok) st_nx = ST_SYNC;
                 else if (char_done) st_nx = ST_HUNT;
        default: st_nx = ST_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OFF;
      jam_q    <= 1'b0;
      jam_pend <= 1'b0;
      prev_s1  <= 1'b0;
      dle_open <= 1'b0;
    end else begin
      st    <= st_nx;
      jam_q <= jam_in;
      if (!rx_en || jam_go) jam_pend <= 1'b0;
      else if (jam_in && !jam_q && jam_sel && st != ST_OFF) jam_pend <= 1'b1;
      if (st != ST_SYNC) begin
        prev_s1  <= 1'b0;
        dle_open <= 1'b0;
      end else if (sync_char) begin
        prev_s1  <= nxt_prev_s1;
        dle_open <= nxt_dle_open;
      end
    end
  end

  assign in_sync = (st == ST_SYNC);

  bsr_hold u_hold (
    .clk, .rst_n, .clear_all(!rx_en), .ld, .val(char_val), .par_bad, .syn_set,
    .dle_upd, .dle_val, .data_read, .status_read, .err_clear,
    .rx_data, .rx_ready, .par_err, .overrun, .syn_det, .dle_det
  );
endmodule

// File: rtl/bsr_checks.sv
module bsr_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       ld,
  input logic       drop_evt,
  input logic       syn_set,
  input logic       data_read,
  input logic       status_read,
  input logic [1:0] len_sel,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       overrun,
  input logic       syn_det,
  input logic       dle_det,
  input logic       in_sync
);
  p_off_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !in_sync && !dle_det && !syn_det));

  p_load_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> rx_ready);

  p_ready_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(ld));

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && rx_ready && !data_read) |=> overrun);

  p_syn_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (syn_set && rx_en) |=> syn_det);

  p_syn_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_read && !syn_set) |=> !syn_det);

  p_drop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(rx_data));

  p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && len_sel == 2'b00) |=> (rx_data[7:5] == 3'b000));
endmodule

bind bisync_rx bsr_checks u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ld(ld), .drop_evt(sync_char && drop),
  .syn_set(syn_set), .data_read(data_read), .status_read(status_read),
  .len_sel(len_sel), .rx_data(rx_data), .rx_ready(rx_ready), .overrun(overrun),
  .syn_det(syn_det), .dle_det(dle_det), .in_sync(in_sync)
);

// File: tb/test_bisync_rx.sv
module test_bisync_rx;
  localparam int CLK_P = 10;
  localparam logic [7:0] S1 = 8'h16, S2 = 8'h3C, DL = 8'h10;

  logic clk = 0, rst_n = 0;
  logic rx_en = 0, rx_bit = 1, bit_tick = 0;
  logic [7:0] syn1 = S1, syn2 = S2, dle = DL;
  logic [1:0] len_sel = 2'b11;
  logic par_en = 0, par_odd = 0, single_syn = 1, transparent = 0, strip_en = 0;
  logic jam_sel = 0, jam_in = 0, err_clear = 0, data_read = 0, status_read = 0;
  logic [7:0] rx_data;
  logic rx_ready, par_err, overrun, syn_det, dle_det, in_sync;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  bisync_rx i_bisync_rx (.*);

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk); rx_bit = b; bit_tick = 1;
    @(negedge clk); bit_tick = 0;
    @(negedge clk);
  endtask

  task automatic put_char(input logic [7:0] v, input bit bad_par = 0);
    int n = 5 + int'(len_sel);
    for (int i = 0; i < n; i++) put_bit(v[i]);
    if (par_en) begin
      logic p = 0;
      for (int i = 0; i < n; i++) p ^= v[i];
      put_bit(p ^ par_odd ^ bad_par);
    end
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b1);
  endtask

  task automatic do_read();   @(negedge clk); data_read = 1;   @(negedge clk); data_read = 0;   endtask
  task automatic do_status(); @(negedge clk); status_read = 1; @(negedge clk); status_read = 0; endtask
  task automatic do_clr();    @(negedge clk); err_clear = 1;   @(negedge clk); err_clear = 0;   endtask
  task automatic restart();
    @(negedge clk); rx_en = 0; repeat (2) @(negedge clk); rx_en = 1; @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 rx_ready", rx_ready, 0); check("R1 syn_det", syn_det, 0);
    check("R1 in_sync", in_sync, 0);   check("R1 rx_data", rx_data, 0);
    check("R1 flags", {par_err, overrun, dle_det}, 0);
  endtask

  task automatic t_single();
    single_syn = 1; transparent = 0; strip_en = 0; restart();
    ones(16); put_char(S1);
    check("R2 in_sync", in_sync, 1); check("R2 syn_det", syn_det, 1);
    check("R2 sync char not loaded", rx_ready, 0);
    do_status(); check("R7 status clears syn_det", syn_det, 0);
    put_char(8'h41);
    check("R4 ready", rx_ready, 1); check("R4 data", rx_data, 8'h41);
    do_read(); check("R7 read clears ready", rx_ready, 0);
    put_char(S1);
    check("R10 single syn in sync", syn_det, 1); check("R8 no strip when off", rx_data, S1);
    put_char(8'h55);
    check("R6 overrun", overrun, 1); check("R6 data", rx_data, 8'h55);
    do_clr(); check("R6 cleared", overrun, 0);
    do_read(); strip_en = 1; do_status();
    put_char(S1);
    check("R8 SYN1 stripped", rx_ready, 0); check("R10 flag kept", syn_det, 1);
  endtask

  task automatic t_double();
    @(negedge clk); rx_en = 0; @(negedge clk);
    check("R13 in_sync off", in_sync, 0); check("R13 syn_det off", syn_det, 0);
    single_syn = 0; strip_en = 1; restart();
    ones(16); put_char(S1);
    check("R3 not yet synced", in_sync, 0);
    put_char(S2);
    check("R3 sync", in_sync, 1); check("R3 syn_det", syn_det, 1); check("R3 no load", rx_ready, 0);
    do_status();
    put_char(S1); check("R8 SYN1 dropped", rx_ready, 0); check("R10 lone SYN1", syn_det, 0);
    put_char(S2); check("R8 SYN2 dropped", rx_ready, 0); check("R10 SYN1-SYN2", syn_det, 1);
    put_char(S2); check("R8 lone SYN2 loaded", rx_ready, 1); check("R8 data", rx_data, S2);
    do_read();
    restart();
    ones(16); put_char(S1); put_char(S1); put_char(S2); ones(16);
    check("R3 S1 S1 S2 no sync", in_sync, 0); check("R3 no syn_det", syn_det, 0);
    check("R3 nothing loaded", rx_ready, 0);
  endtask

  task automatic t_transp();
    single_syn = 1; transparent = 1; strip_en = 1; restart();
    ones(16); put_char(S1); check("R2 sync transparent", in_sync, 1);
    do_status();
    put_char(DL); check("R9 DLE dropped", rx_ready, 0);
    put_char(S1); check("R9 DLE-SYN1 dropped", rx_ready, 0); check("R10 DLE-SYN1 syn_det", syn_det, 1);
    do_status();
    put_char(DL); put_char(DL);
    check("R9 second DLE loaded", rx_ready, 1); check("R9 data DLE", rx_data, DL);
    check("R11 DLE-DLE no flag", dle_det, 0);
    do_read();
    put_char(DL); put_char(8'h41);
    check("R11 dle_det set", dle_det, 1); check("R11 data", rx_data, 8'h41);
    do_read();
    put_char(S1); check("R9 plain SYN1 loaded", rx_data, S1); check("R9 ready", rx_ready, 1);
    check("R10 plain SYN1 no syn_det", syn_det, 0);
    do_read(); do_clr(); check("R11 err_clear", dle_det, 0);
    put_char(DL); put_char(8'h42); check("R11 set again", dle_det, 1);
    @(negedge clk); rx_en = 0; @(negedge clk);
    check("R13 dle_det off", dle_det, 0); check("R13 ready off", rx_ready, 0);
    transparent = 0; strip_en = 0;
  endtask

  task automatic t_parity();
    single_syn = 1; par_en = 1; par_odd = 0; restart();
    ones(16); put_char(S1); check("R5 sync with parity", in_sync, 1);
    put_char(8'h41); check("R5 data", rx_data, 8'h41); check("R5 good parity", par_err, 0);
    do_read();
    put_char(8'h43, 1); check("R5 bad even parity", par_err, 1);
    do_clr(); check("R5 clear", par_err, 0); do_read();
    par_odd = 1;
    put_char(8'h07); check("R5 good odd parity", par_err, 0); check("R5 odd data", rx_data, 8'h07);
    do_read(); par_en = 0; par_odd = 0;
  endtask

  task automatic t_jam();
    jam_sel = 1; len_sel = 2'b00; restart();
    ones(8); for (int i = 0; i < 8; i++) put_bit(S1[i]);
    check("R12 hunt disabled", in_sync, 0);
    @(negedge clk); jam_in = 1; @(negedge clk); jam_in = 0;
    put_bit(1'b0);
    check("R12 in_sync after jam bit", in_sync, 1); check("R12 syn_det", syn_det, 1);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    check("R12 char aligned", rx_data, 8'h1A); check("R4 5-bit ready", rx_ready, 1);
    do_status(); check("R12 status clears", syn_det, 0);
    do_read();
    len_sel = 2'b01;
    put_char(8'h3F); check("R4 6-bit data", rx_data, 8'h3F);
    do_read(); jam_sel = 0; len_sel = 2'b11;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_single();
    t_double();
    t_transp();
    t_parity();
    t_jam();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule